// File: doc/BRIEF.md
# Configurable GPIO Port Controller

An eight-pin general-purpose I/O port with a small synchronous register bus. Two registers are reachable: a data register (address 0) and a mode register (address 1). The mode register holds a 2-bit mode code for every pin. The code picks one of four behaviours for the pin: handing the pad to a peripheral, driving the stored data bit, or acting as an input with the pull-up switched on or off.

The pad side of the block has three outputs per pin: data, output enable and pull-up enable. Pad input levels come in through a two-flop synchronizer.

A read of the data register is decided pin by pin:
- A pin in peripheral or output mode returns its latched bit.
- A pin in either input mode returns its synchronized pad level.

A parameter mask marks pins that are input-only. Such a pin never drives its pad.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset the mode register reads 0xFFFF, every pin is an input with the pull-up off, the stored data bits are 0, and pad_oe and pad_pu are all zero.
- R2: A register is written on the rising clock edge where bus_we is high. bus_addr 0 loads bus_wdata[7:0] into the data register. bus_addr 1 loads bus_wdata[15:0] into the mode register. The mode of pin n sits in bits [2n+1:2n]. With bus_we low, neither register changes.
- R3: Mode code 00 (peripheral): pad_out and pad_oe of the pin follow alt_out and alt_oe. A data-register write changes neither of them, and a read returns the stored bit.
- R4: Mode code 01 (output): pad_out equals the stored data bit, pad_oe is 1, and a read returns the stored bit.
- R5: Mode codes 10 and 11 (input): pad_oe is 0, so a data-register write has no effect on the pin. A read returns the synchronized pad level.
- R6: pad_pu of a pin is 1 exactly when its mode code is 10.
- R7: A pin set in the INPUT_ONLY_MASK parameter (default: pin 5) never asserts pad_oe, in any mode.
- R8: A change on pad_in appears in data-register read-back after two rising clock edges, and not after one.
- R9: bus_rdata is combinational from bus_addr. Address 0 gives the per-pin read bits in [7:0] with [15:8] zero. Address 1 gives the full mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 1 | Register select: 0 data, 1 mode |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| alt_out | input | 8 | Peripheral data per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_out | output | 8 | Pad output data |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
Some properties are checked by assertions on every cycle:
- The register update on a write strobe and the post-reset register state.
- The pull-up being tied to mode code 10.
- The input-only pin never enabling its driver.
- The two-cycle latency of the synchronizer.

Other behaviour only shows up in the bench's scenarios:
- The per-pin choice between stored bit and pad level on read-back.
- Peripheral pass-through.
- The absence of any pad effect from data writes in peripheral or input mode.
- Mixed-mode settings where neighbouring pins use different codes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DEF_PINS = 8;
    localparam int MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        PM_ALT      = 2'b00,
        PM_OUT      = 2'b01,
        PM_IN_PU    = 2'b10,
        PM_IN_FLOAT = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic dout;
        logic oe;
        logic pu;
        logic rd;
    } pin_drive_t;

    function automatic logic mode_is_input(pin_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

    // Cycles since reset, saturating at 2, so the latency check only looks
    // back over cycles that followed reset.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    a_r8_two_cycle_latency: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_port_pkg::*;
#(
    parameter bit INPUT_ONLY = 1'b0
) (
    input  pin_mode_e  mode,
    input  logic       data_bit,
    input  logic       alt_dout,
    input  logic       alt_en,
    input  logic       pin_level,
    output pin_drive_t drv
);
    always_comb begin
        drv      = '0;
        drv.pu   = (mode == PM_IN_PU);
        drv.rd   = mode_is_input(mode) ? pin_level : data_bit;
        drv.dout = (mode == PM_ALT) ? alt_dout : data_bit;
        unique case (mode)
            PM_ALT:  drv.oe = alt_en & ~INPUT_ONLY;
            PM_OUT:  drv.oe = ~INPUT_ONLY;
            default: drv.oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int               NUM_PINS        = DEF_PINS,
    parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 8'h20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_we,
    input  logic                       bus_addr,
    input  logic [2*NUM_PINS-1:0]      bus_wdata,
    output logic [2*NUM_PINS-1:0]      bus_rdata,
    input  logic [NUM_PINS-1:0]        alt_out,
    input  logic [NUM_PINS-1:0]        alt_oe,
    input  logic [NUM_PINS-1:0]        pad_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS-1:0]        pad_pu
);
    localparam int CTRL_W = MODE_W * NUM_PINS;

    logic [NUM_PINS-1:0] data_q;
    logic [CTRL_W-1:0]   ctrl_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] rd_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '1;
        end else if (bus_we) begin
            if (bus_addr) ctrl_q <= bus_wdata;
            else          data_q <= bus_wdata[NUM_PINS-1:0];
        end
    end

    gpio_sync #(.W(NUM_PINS)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (pin_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_drive_t drv;
        pin_mode_e  mode;
        assign mode = pin_mode_e'(ctrl_q[MODE_W*i +: MODE_W]);

        gpio_pin_cell #(.INPUT_ONLY(INPUT_ONLY_MASK[i])) cell_i (
            .mode      (mode),
            .data_bit  (data_q[i]),
            .alt_dout  (alt_out[i]),
            .alt_en    (alt_oe[i]),
            .pin_level (pin_sync[i]),
            .drv       (drv)
        );

        assign pad_out[i] = drv.dout;
        assign pad_oe[i]  = drv.oe;
        assign pad_pu[i]  = drv.pu;
        assign rd_bits[i] = drv.rd;

        a_r6_pullup_mode: assert property (@(posedge clk) disable iff (rst)
            pad_pu[i] |-> (ctrl_q[MODE_W*i +: MODE_W] == 2'b10));

        if (INPUT_ONLY_MASK[i]) begin : g_inonly
            a_r7_no_drive: assert property (@(posedge clk) disable iff (rst)
                !pad_oe[i]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) bus_rdata = ctrl_q;
        else          bus_rdata[NUM_PINS-1:0] = rd_bits;
    end

    a_r2_data_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_addr) |=> (data_q == $past(bus_wdata[NUM_PINS-1:0])));

    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr) |=> (ctrl_q == $past(bus_wdata)));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(ctrl_q) && $stable(data_q)));

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_q == '1 && data_q == '0 && pad_oe == '0 && pad_pu == '0));

endmodule

// File: tb/gpio_port_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_port_ctrl_tb_top;

    localparam logic [7:0] IO_MASK = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  alt_out = '0;
    logic [7:0]  alt_oe = '0;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pad_pu;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .alt_out(alt_out), .alt_oe(alt_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // {mode, data, alt_out, alt_oe, pad_in}
    localparam int NV = 6;
    localparam logic [47:0] VEC [NV] = '{
        {16'h5555, 8'hA5, 8'h00, 8'h00, 8'h3C},
        {16'h0000, 8'hFF, 8'h5A, 8'hF0, 8'h00},
        {16'hAAAA, 8'h12, 8'hFF, 8'hFF, 8'hC3},
        {16'hFFFF, 8'h34, 8'h00, 8'hFF, 8'h96},
        {16'h1B1B, 8'h0F, 8'hFF, 8'hFF, 8'h55},
        {16'hE4E4, 8'hF0, 8'h0F, 8'hAA, 8'h33}
    };

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic model(input logic [15:0] m, input logic [7:0] d, input logic [7:0] ao,
                         input logic [7:0] ae, input logic [7:0] p,
                         output logic [7:0] eo, output logic [7:0] eoe,
                         output logic [7:0] epu, output logic [7:0] erd);
        for (int i = 0; i < 8; i++) begin
            logic [1:0] c;
            c = m[2*i +: 2];
            eo[i]  = (c == 2'b00) ? ao[i] : d[i];
            eoe[i] = (c == 2'b00) ? (ae[i] & ~IO_MASK[i]) :
                     (c == 2'b01) ? ~IO_MASK[i] : 1'b0;
            epu[i] = (c == 2'b10);
            erd[i] = c[1] ? p[i] : d[i];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] eo, eoe, epu, erd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        bus_addr = 1'b1; #0.5;
        check("R1 mode reset", bus_rdata, 16'hFFFF);
        check("R1 oe reset", {8'h0, pad_oe}, 16'h0);
        check("R1 pu reset", {8'h0, pad_pu}, 16'h0);
        // stored data after reset seen through output mode
        wr(1'b1, 16'h5555);
        bus_addr = 1'b0; #0.5;
        check("R1 data reset", bus_rdata, 16'h0000);

        // R2 no write without strobe
        @(negedge clk);
        bus_addr = 1'b0; bus_wdata = 16'h0077; bus_we = 1'b0;
        @(negedge clk); #0.5;
        check("R2 no strobe", bus_rdata, 16'h0000);

        // table of vectors
        for (int v = 0; v < NV; v++) begin
            logic [15:0] m;
            logic [7:0] d, ao, ae, p;
            {m, d, ao, ae, p} = VEC[v];
            wr(1'b1, m);
            wr(1'b0, {8'h00, d});
            alt_out = ao; alt_oe = ae; pad_in = p;
            repeat (3) @(negedge clk);
            bus_addr = 1'b0; #0.5;
            model(m, d, ao, ae, p, eo, eoe, epu, erd);
            check("R3 R4 pad_out", {8'h0, pad_out}, {8'h0, eo});
            check("R4 R5 R7 pad_oe", {8'h0, pad_oe}, {8'h0, eoe});
            check("R6 pad_pu", {8'h0, pad_pu}, {8'h0, epu});
            check("R5 R9 readback", bus_rdata, {8'h0, erd});
            bus_addr = 1'b1; #0.5;
            check("R2 R9 mode readback", bus_rdata, m);
        end

        // R3: data write in peripheral mode leaves the pad alone
        wr(1'b1, 16'h0000);
        alt_out = 8'h00; alt_oe = 8'h0F;
        wr(1'b0, 16'h00FF);
        #0.5;
        check("R3 pad unchanged", {8'h0, pad_out}, 16'h0000);
        check("R3 oe follows alt", {8'h0, pad_oe}, 16'h000F);
        bus_addr = 1'b0; #0.5;
        check("R3 stored readback", bus_rdata, 16'h00FF);

        // R7: input-only pin in output mode
        wr(1'b1, 16'h5555);
        #0.5;
        check("R7 inonly oe", {8'h0, pad_oe}, 16'h00DF);

        // R8: synchronizer latency
        wr(1'b1, 16'hFFFF);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hFF;
        bus_addr = 1'b0;
        @(negedge clk); #0.5;
        check("R8 after one edge", bus_rdata, 16'h0000);
        @(negedge clk); #0.5;
        check("R8 after two edges", bus_rdata, 16'h00FF);
        // R5: write in input mode, pin not driven
        wr(1'b0, 16'h0000);
        #0.5;
        check("R5 oe off", {8'h0, pad_oe}, 16'h0000);
        check("R5 reads pad", bus_rdata, 16'h00FF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule